// File: doc/BRIEF.md
# Use-Count Register Cache

This block is a small two-way set-associative store of recently produced physical register values. It sits in front of a larger register file in an out-of-order core. Every entry holds the register number as its tag, the value, and a count of consumers that have not yet read it. Insertion and replacement are driven by that count, not by recency. A value whose consumers were all served by the bypass network is never stored. When a set is full, the entry with the fewest outstanding readers is the one replaced.

The set a register lands in is not taken from bits of the register number. The allocator assigns a set index when it hands out a physical register. That index is kept in a side table indexed by register number, and every lookup, write and invalidate reads that table to find its set. Read ports answer in the same cycle from the state held at the last clock edge. Writes, invalidates, flushes and use-count decrements take effect at the next edge.

Top module: `regcache_top`

## Requirements
- R1: After reset, and in the cycle after any cycle with `flush` high, every read returns `rd_hit` = 0. A flush has priority over a write or an invalidate in the same cycle.
- R2: A write stores the value with a remaining-use count equal to `wr_pred - wr_byp`, or 0 when `wr_byp >= wr_pred`. A write whose remaining count is 0 is not stored, and it clears any copy of that register already held in its set.
- R3: A read of a register that is held returns `rd_hit` = 1 with the value of the latest write, combinationally, in any cycle after the write's clock edge. A read of a register that is not held returns `rd_hit` = 0.
- R4: A read of the register being written in the same cycle returns `rd_hit` = 0.
- R5: A new value goes into an invalid way when one exists, with way 0 taken before way 1.
- R6: When both ways are valid and the counts differ, the way with the smaller remaining-use count is replaced. A count of 0 is therefore always chosen over any nonzero count.
- R7: When both ways are valid and the counts are equal, a per-set flag picks the victim. The flag points at the way that was not touched last, where a touch is an insertion, an in-place update or a read hit. Read ports are applied in port order and a write overrides reads. The flag resets to select way 0.
- R8: Each read hit lowers the entry's remaining-use count by one, saturating at 0. Hits from several ports on one entry in one cycle subtract their total. The entry stays valid at count 0.
- R9: The set is the 5-bit index last written for that register through `alloc_en`/`alloc_preg`/`alloc_idx`, taking effect from the next cycle. Registers with equal low bits but different indices never conflict. Registers with one index share a single set. The table resets to index 0.
- R10: `inv_en` clears the entry of `inv_preg` in its set at the next edge. A write of that same register in the same cycle is dropped. A write to another register may reuse the cleared way in that cycle.
- R11: A write to a register already held in its set updates that way in place, setting value and count, rather than taking a second way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| flush | input | 1 | Clear every entry |
| alloc_en | input | 1 | Record a set index for a register |
| alloc_preg | input | PREG_W | Register receiving the index |
| alloc_idx | input | SET_W | Set index assigned to it |
| wr_en | input | 1 | Produced value valid |
| wr_preg | input | PREG_W | Register number of the produced value |
| wr_data | input | DATA_W | Produced value |
| wr_pred | input | 4 | Predicted total consumers |
| wr_byp | input | 4 | Consumers already served by bypass |
| inv_en | input | 1 | Register freed, drop its entry |
| inv_preg | input | PREG_W | Freed register number |
| rd_en | input | NUM_RD | Per-port read request |
| rd_preg | input | NUM_RD*PREG_W | Per-port register number, port 0 in the low bits |
| rd_hit | output | NUM_RD | Per-port hit |
| rd_data | output | NUM_RD*DATA_W | Per-port value, zero on a miss |

## Verification
The clocked properties assume that the index of a register is reassigned only in a cycle that also invalidates that register. Without this, a stale copy could remain in the old set. The properties that look back one cycle also stand down when an allocation happened in that cycle. The random stimulus keeps to this assumption by pairing every allocation with an invalidate of the same register. Write, read, invalidate and flush requests are otherwise drawn freely. Reads are drawn from recently written registers so that hits, evictions and multi-port decrements occur often.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int unsigned RC_CNT_W = 4;

  typedef logic [RC_CNT_W-1:0] use_cnt_t;

  typedef enum logic {
    WAY_0 = 1'b0,
    WAY_1 = 1'b1
  } way_e;

  // consumers left after the bypass network took its share
  function automatic use_cnt_t rem_uses(use_cnt_t pred, use_cnt_t served);
    return (pred > served) ? use_cnt_t'(pred - served) : '0;
  endfunction

  // count minus amount, floored at zero
  function automatic use_cnt_t sat_dec(use_cnt_t cnt, use_cnt_t amt);
    return (amt >= cnt) ? '0 : use_cnt_t'(cnt - amt);
  endfunction
endpackage

// File: rtl/rc_index_table.sv
module rc_index_table #(
  parameter int unsigned PREG_W     = 7,
  parameter int unsigned SET_W      = 5,
  parameter int unsigned NUM_LOOKUP = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           set_en,
  input  logic [PREG_W-1:0]              set_preg,
  input  logic [SET_W-1:0]               set_idx,
  input  logic [NUM_LOOKUP*PREG_W-1:0]   lk_preg,
  output logic [NUM_LOOKUP*SET_W-1:0]    lk_idx
);
  localparam int unsigned NUM_PREG = 1 << PREG_W;

  logic [SET_W-1:0] tbl_q [NUM_PREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PREG; i++) tbl_q[i] <= '0;
    end else if (set_en) begin
      tbl_q[set_preg] <= set_idx;
    end
  end

  for (genvar k = 0; k < NUM_LOOKUP; k++) begin : g_lk
    assign lk_idx[k*SET_W +: SET_W] = tbl_q[lk_preg[k*PREG_W +: PREG_W]];
  end
endmodule

// File: rtl/rc_victim_pick.sv
module rc_victim_pick
  import rc_pkg::*;
(
  input  logic [1:0] avail,
  input  use_cnt_t   cnt0,
  input  use_cnt_t   cnt1,
  input  logic       lru,
  output way_e       victim
);
  always_comb begin
    if (!avail[0])         victim = WAY_0;
    else if (!avail[1])    victim = WAY_1;
    else if (cnt0 < cnt1)  victim = WAY_0;
    else if (cnt1 < cnt0)  victim = WAY_1;
    else                   victim = lru ? WAY_1 : WAY_0;
  end
endmodule

// File: rtl/rc_set.sv
module rc_set
  import rc_pkg::*;
#(
  parameter int unsigned NUM_RD = 2,
  parameter int unsigned PREG_W = 7,
  parameter int unsigned DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic [NUM_RD-1:0]          rd_sel,
  input  logic [NUM_RD*PREG_W-1:0]   rd_tag,
  output logic [NUM_RD-1:0]          rd_hit,
  output logic [NUM_RD*DATA_W-1:0]   rd_data,
  input  logic                       wr_sel,
  input  logic [PREG_W-1:0]          wr_tag,
  input  logic [DATA_W-1:0]          wr_data,
  input  use_cnt_t                   wr_rem,
  input  logic                       inv_sel,
  input  logic [PREG_W-1:0]          inv_tag
);
  localparam int unsigned NUM_WAYS = 2;

  logic [NUM_WAYS-1:0] valid_q, valid_d;
  logic [PREG_W-1:0]   tag_q  [NUM_WAYS];
  logic [PREG_W-1:0]   tag_d  [NUM_WAYS];
  logic [DATA_W-1:0]   data_q [NUM_WAYS];
  logic [DATA_W-1:0]   data_d [NUM_WAYS];
  use_cnt_t            cnt_q  [NUM_WAYS];
  use_cnt_t            cnt_d  [NUM_WAYS];
  logic                lru_q, lru_d;

  logic [NUM_WAYS-1:0] hit_way [NUM_RD];
  use_cnt_t            dec_amt [NUM_WAYS];
  logic [NUM_WAYS-1:0] inv_hit, wr_match, avail;
  way_e                victim;
  logic                upd_en;
  logic                tgt;

  // lookups against the state of the last edge
  always_comb begin
    for (int p = 0; p < NUM_RD; p++) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        hit_way[p][w] = rd_sel[p] & valid_q[w] &
                        (tag_q[w] == rd_tag[p*PREG_W +: PREG_W]);
      end
      rd_hit[p] = |hit_way[p];
      rd_data[p*DATA_W +: DATA_W] = hit_way[p][0] ? data_q[0] :
                                    hit_way[p][1] ? data_q[1] : '0;
    end
  end

  always_comb begin
    for (int w = 0; w < NUM_WAYS; w++) begin
      inv_hit[w]  = inv_sel & valid_q[w] & (tag_q[w] == inv_tag);
      avail[w]    = valid_q[w] & ~inv_hit[w];
      wr_match[w] = wr_sel & avail[w] & (tag_q[w] == wr_tag);
      dec_amt[w]  = '0;
      for (int p = 0; p < NUM_RD; p++) begin
        dec_amt[w] = dec_amt[w] + use_cnt_t'(hit_way[p][w]);
      end
    end
  end

  rc_victim_pick u_pick (
    .avail  (avail),
    .cnt0   (cnt_q[0]),
    .cnt1   (cnt_q[1]),
    .lru    (lru_q),
    .victim (victim)
  );

  // next state: reads, invalidate, write, flush in rising priority
  always_comb begin
    valid_d = valid_q & ~inv_hit;
    lru_d   = lru_q;
    tgt     = 1'b0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      tag_d[w]  = tag_q[w];
      data_d[w] = data_q[w];
      cnt_d[w]  = sat_dec(cnt_q[w], dec_amt[w]);
    end
    for (int p = 0; p < NUM_RD; p++) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        if (hit_way[p][w]) lru_d = (w == 0);
      end
    end
    if (wr_sel) begin
      if (|wr_match) begin
        tgt = wr_match[1];
        if (wr_rem == '0) begin
          valid_d[tgt] = 1'b0;
        end else begin
          data_d[tgt] = wr_data;
          cnt_d[tgt]  = wr_rem;
          lru_d       = ~tgt;
        end
      end else if (wr_rem != '0) begin
        tgt          = victim;
        valid_d[tgt] = 1'b1;
        tag_d[tgt]   = wr_tag;
        data_d[tgt]  = wr_data;
        cnt_d[tgt]   = wr_rem;
        lru_d        = ~tgt;
      end
    end
    if (flush) valid_d = '0;
  end

  assign upd_en = flush | wr_sel | inv_sel | (|rd_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      lru_q   <= 1'b0;
      for (int w = 0; w < NUM_WAYS; w++) cnt_q[w] <= '0;
    end else if (upd_en) begin
      valid_q <= valid_d;
      lru_q   <= lru_d;
      for (int w = 0; w < NUM_WAYS; w++) cnt_q[w] <= cnt_d[w];
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        tag_q[w]  <= tag_d[w];
        data_q[w] <= data_d[w];
      end
    end
  end
endmodule

// File: rtl/regcache_top.sv
module regcache_top
  import rc_pkg::*;
#(
  parameter int unsigned PREG_W = 7,
  parameter int unsigned SET_W  = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NUM_RD = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       alloc_en,
  input  logic [PREG_W-1:0]          alloc_preg,
  input  logic [SET_W-1:0]           alloc_idx,
  input  logic                       wr_en,
  input  logic [PREG_W-1:0]          wr_preg,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [RC_CNT_W-1:0]        wr_pred,
  input  logic [RC_CNT_W-1:0]        wr_byp,
  input  logic                       inv_en,
  input  logic [PREG_W-1:0]          inv_preg,
  input  logic [NUM_RD-1:0]          rd_en,
  input  logic [NUM_RD*PREG_W-1:0]   rd_preg,
  output logic [NUM_RD-1:0]          rd_hit,
  output logic [NUM_RD*DATA_W-1:0]   rd_data
);
  localparam int unsigned NUM_SETS = 1 << SET_W;
  localparam int unsigned NUM_LK   = NUM_RD + 2;
  localparam int unsigned LK_WR    = NUM_RD;
  localparam int unsigned LK_INV   = NUM_RD + 1;

  logic [NUM_LK*PREG_W-1:0] lk_preg;
  logic [NUM_LK*SET_W-1:0]  lk_idx;
  logic [SET_W-1:0]         rd_idx [NUM_RD];
  logic [SET_W-1:0]         wr_idx, inv_idx;
  logic [NUM_RD-1:0]        rd_go;
  logic                     wr_go;
  use_cnt_t                 wr_rem;

  logic [NUM_RD-1:0]        set_hit  [NUM_SETS];
  logic [NUM_RD*DATA_W-1:0] set_data [NUM_SETS];

  assign lk_preg = {inv_preg, wr_preg, rd_preg};

  rc_index_table #(
    .PREG_W     (PREG_W),
    .SET_W      (SET_W),
    .NUM_LOOKUP (NUM_LK)
  ) u_idx (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (alloc_en),
    .set_preg (alloc_preg),
    .set_idx  (alloc_idx),
    .lk_preg  (lk_preg),
    .lk_idx   (lk_idx)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    assign rd_idx[p] = lk_idx[p*SET_W +: SET_W];
    // a value written this cycle is served by the bypass network
    assign rd_go[p]  = rd_en[p] & ~(wr_en & (wr_preg == rd_preg[p*PREG_W +: PREG_W]));
  end

  assign wr_idx  = lk_idx[LK_WR*SET_W  +: SET_W];
  assign inv_idx = lk_idx[LK_INV*SET_W +: SET_W];
  assign wr_go   = wr_en & ~(inv_en & (inv_preg == wr_preg));
  assign wr_rem  = rem_uses(wr_pred, wr_byp);

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic [NUM_RD-1:0] sel_rd;
    logic              sel_wr, sel_inv;

    always_comb begin
      for (int p = 0; p < NUM_RD; p++) begin
        sel_rd[p] = rd_go[p] & (rd_idx[p] == SET_W'(s));
      end
    end
    assign sel_wr  = wr_go  & (wr_idx  == SET_W'(s));
    assign sel_inv = inv_en & (inv_idx == SET_W'(s));

    rc_set #(
      .NUM_RD (NUM_RD),
      .PREG_W (PREG_W),
      .DATA_W (DATA_W)
    ) u_set (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .rd_sel  (sel_rd),
      .rd_tag  (rd_preg),
      .rd_hit  (set_hit[s]),
      .rd_data (set_data[s]),
      .wr_sel  (sel_wr),
      .wr_tag  (wr_preg),
      .wr_data (wr_data),
      .wr_rem  (wr_rem),
      .inv_sel (sel_inv),
      .inv_tag (inv_preg)
    );
  end

  // at most one set is selected per port, so an OR merges them
  always_comb begin
    rd_hit  = '0;
    rd_data = '0;
    for (int s = 0; s < NUM_SETS; s++) begin
      rd_hit  = rd_hit  | set_hit[s];
      rd_data = rd_data | set_data[s];
    end
  end
endmodule

// File: rtl/regcache_chk.sv
module regcache_chk
  import rc_pkg::*;
#(
  parameter int unsigned PREG_W = 7,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NUM_RD = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     flush,
  input logic                     alloc_en,
  input logic                     wr_en,
  input logic [PREG_W-1:0]        wr_preg,
  input logic [DATA_W-1:0]        wr_data,
  input logic [RC_CNT_W-1:0]      wr_pred,
  input logic [RC_CNT_W-1:0]      wr_byp,
  input logic                     inv_en,
  input logic [PREG_W-1:0]        inv_preg,
  input logic [NUM_RD-1:0]        rd_en,
  input logic [NUM_RD*PREG_W-1:0] rd_preg,
  input logic [NUM_RD-1:0]        rd_hit,
  input logic [NUM_RD*DATA_W-1:0] rd_data
);
  p_flush_empties_r1: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (rd_hit == '0));

  for (genvar p = 0; p < NUM_RD; p++) begin : g_port
    p_same_cycle_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_en[p] && (rd_preg[p*PREG_W +: PREG_W] == wr_preg)) |-> !rd_hit[p]);

    p_freed_misses_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(inv_en) && !$past(alloc_en) && rd_en[p] &&
       (rd_preg[p*PREG_W +: PREG_W] == $past(inv_preg))) |-> !rd_hit[p]);

    p_bypassed_not_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en) && ($past(wr_pred) <= $past(wr_byp)) && !$past(alloc_en) &&
       rd_en[p] && (rd_preg[p*PREG_W +: PREG_W] == $past(wr_preg))) |-> !rd_hit[p]);

    p_write_then_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en) && ($past(wr_pred) > $past(wr_byp)) && !$past(flush) &&
       !$past(alloc_en) && !($past(inv_en) && ($past(inv_preg) == $past(wr_preg))) &&
       rd_en[p] && (rd_preg[p*PREG_W +: PREG_W] == $past(wr_preg)) &&
       !(wr_en && (wr_preg == $past(wr_preg))))
      |-> (rd_hit[p] && (rd_data[p*DATA_W +: DATA_W] == $past(wr_data))));
  end
endmodule

bind regcache_top regcache_chk #(
  .PREG_W (PREG_W),
  .DATA_W (DATA_W),
  .NUM_RD (NUM_RD)
) u_regcache_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .flush    (flush),
  .alloc_en (alloc_en),
  .wr_en    (wr_en),
  .wr_preg  (wr_preg),
  .wr_data  (wr_data),
  .wr_pred  (wr_pred),
  .wr_byp   (wr_byp),
  .inv_en   (inv_en),
  .inv_preg (inv_preg),
  .rd_en    (rd_en),
  .rd_preg  (rd_preg),
  .rd_hit   (rd_hit),
  .rd_data  (rd_data)
);

// File: tb/test_regcache_top.sv
`timescale 1ns/1ps
module test_regcache_top;
  localparam int PREG_W   = 7;
  localparam int SET_W    = 5;
  localparam int DATA_W   = 32;
  localparam int NUM_RD   = 2;
  localparam int NUM_PREG = 1 << PREG_W;
  localparam int NUM_SETS = 1 << SET_W;

  logic                     clk = 1'b0;
  logic                     rst_n;
  logic                     flush, alloc_en, wr_en, inv_en;
  logic [PREG_W-1:0]        alloc_preg, wr_preg, inv_preg;
  logic [SET_W-1:0]         alloc_idx;
  logic [DATA_W-1:0]        wr_data;
  logic [3:0]               wr_pred, wr_byp;
  logic [NUM_RD-1:0]        rd_en;
  logic [NUM_RD*PREG_W-1:0] rd_preg;
  logic [NUM_RD-1:0]        rd_hit;
  logic [NUM_RD*DATA_W-1:0] rd_data;

  always #2.5 clk = ~clk;

  regcache_top #(.PREG_W(PREG_W), .SET_W(SET_W), .DATA_W(DATA_W), .NUM_RD(NUM_RD)) i_regcache_top (
    .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_en(alloc_en), .alloc_preg(alloc_preg),
    .alloc_idx(alloc_idx), .wr_en(wr_en), .wr_preg(wr_preg), .wr_data(wr_data),
    .wr_pred(wr_pred), .wr_byp(wr_byp), .inv_en(inv_en), .inv_preg(inv_preg),
    .rd_en(rd_en), .rd_preg(rd_preg), .rd_hit(rd_hit), .rd_data(rd_data));

  // reference state built from the requirements
  bit                mv [NUM_SETS][2];
  logic [PREG_W-1:0] mt [NUM_SETS][2];
  logic [DATA_W-1:0] md [NUM_SETS][2];
  int                mc [NUM_SETS][2];
  bit                ml [NUM_SETS];
  int                mi [NUM_PREG];

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  string cur_req = "R1";
  int    recent [8];

  task automatic clear_in();
    flush = 0; alloc_en = 0; alloc_preg = '0; alloc_idx = '0;
    wr_en = 0; wr_preg = '0; wr_data = '0; wr_pred = '0; wr_byp = '0;
    inv_en = 0; inv_preg = '0; rd_en = '0; rd_preg = '0;
  endtask

  task automatic check_reads();
    for (int p = 0; p < NUM_RD; p++) begin
      logic [PREG_W-1:0] rp;
      bit                eh;
      logic [DATA_W-1:0] ed;
      int                s;
      rp = rd_preg[p*PREG_W +: PREG_W];
      eh = 0; ed = '0; s = mi[rp];
      if (rd_en[p] && !(wr_en && wr_preg == rp)) begin
        for (int w = 0; w < 2; w++) begin
          if (mv[s][w] && mt[s][w] == rp) begin eh = 1; ed = md[s][w]; end
        end
      end
      checks++;
      if (rd_hit[p] !== eh || (eh && rd_data[p*DATA_W +: DATA_W] !== ed)) begin
        errors++;
        $display("FAIL %s port %0d preg %0d: hit %0b data %h, expected hit %0b data %h",
                 cur_req, p, rp, rd_hit[p], rd_data[p*DATA_W +: DATA_W], eh, ed);
      end
    end
  endtask

  task automatic commit();
    int is, ws, inv_w, tgt, h, rem;
    bit av [2];
    bit do_wr;
    is = mi[inv_preg]; inv_w = -1;
    if (inv_en) begin
      for (int w = 0; w < 2; w++) if (mv[is][w] && mt[is][w] == inv_preg) inv_w = w;
    end
    do_wr = wr_en && !(inv_en && inv_preg == wr_preg);
    ws  = mi[wr_preg];
    rem = (wr_pred > wr_byp) ? int'(wr_pred) - int'(wr_byp) : 0;
    h = -1; tgt = -1;
    if (do_wr) begin
      for (int w = 0; w < 2; w++) av[w] = mv[ws][w] && !(ws == is && w == inv_w);
      for (int w = 0; w < 2; w++) if (av[w] && mt[ws][w] == wr_preg) h = w;
      if (h < 0 && rem > 0) begin
        if (!av[0]) tgt = 0;
        else if (!av[1]) tgt = 1;
        else if (mc[ws][0] < mc[ws][1]) tgt = 0;
        else if (mc[ws][1] < mc[ws][0]) tgt = 1;
        else tgt = int'(ml[ws]);
      end
    end
    for (int p = 0; p < NUM_RD; p++) begin
      logic [PREG_W-1:0] rp;
      int s;
      rp = rd_preg[p*PREG_W +: PREG_W];
      s  = mi[rp];
      if (rd_en[p] && !(wr_en && wr_preg == rp)) begin
        for (int w = 0; w < 2; w++) begin
          if (mv[s][w] && mt[s][w] == rp) begin
            if (mc[s][w] > 0) mc[s][w]--;
            ml[s] = (w == 0);
          end
        end
      end
    end
    if (inv_w >= 0) mv[is][inv_w] = 0;
    if (do_wr) begin
      if (h >= 0) begin
        if (rem == 0) mv[ws][h] = 0;
        else begin md[ws][h] = wr_data; mc[ws][h] = rem; ml[ws] = (h == 0); end
      end else if (tgt >= 0) begin
        mv[ws][tgt] = 1; mt[ws][tgt] = wr_preg; md[ws][tgt] = wr_data;
        mc[ws][tgt] = rem; ml[ws] = (tgt == 0);
      end
    end
    if (flush) for (int s = 0; s < NUM_SETS; s++) begin mv[s][0] = 0; mv[s][1] = 0; end
    if (alloc_en) mi[alloc_preg] = int'(alloc_idx);
  endtask

  task automatic step();
    #1;
    check_reads();
    commit();
    @(negedge clk);
    clear_in();
  endtask

  task automatic do_alloc(int p, int i);
    alloc_en = 1; alloc_preg = PREG_W'(p); alloc_idx = SET_W'(i);
    inv_en = 1; inv_preg = PREG_W'(p);
    step();
  endtask

  task automatic do_write(int p, int d, int pred, int byp);
    wr_en = 1; wr_preg = PREG_W'(p); wr_data = DATA_W'(d);
    wr_pred = 4'(pred); wr_byp = 4'(byp);
    step();
  endtask

  task automatic do_read(int p0, int p1);
    rd_en = '1; rd_preg = {PREG_W'(p1), PREG_W'(p0)};
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog: run still busy, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h5EED_0042;
    void'($urandom(seed));
    for (int s = 0; s < NUM_SETS; s++) begin
      mv[s][0] = 0; mv[s][1] = 0; mc[s][0] = 0; mc[s][1] = 0; ml[s] = 0;
    end
    for (int i = 0; i < NUM_PREG; i++) mi[i] = 0;
    for (int i = 0; i < 8; i++) recent[i] = i;
    clear_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state, nothing hits
    cur_req = "R1";
    do_read(0, 5); do_read(127, 64);

    // R9: index table loaded with a spread that ignores low bits
    cur_req = "R9";
    for (int p = 0; p < NUM_PREG; p++) do_alloc(p, (p * 7 + 3) % NUM_SETS);
    // equal low bits (8 and 40), different sets: both retained
    do_alloc(8, 1); do_alloc(40, 2);
    do_write(8, 32'h0808, 3, 0); do_write(40, 32'h4040, 3, 0);
    do_read(8, 40);
    // different low bits, same set: only two survive
    do_alloc(9, 6); do_alloc(17, 6); do_alloc(33, 6);
    do_write(9, 32'h09, 4, 0); do_write(17, 32'h17, 2, 0); do_write(33, 32'h33, 3, 0);
    do_read(9, 17); do_read(33, 8);

    // R2: fully bypassed value is not kept and clears a held copy
    cur_req = "R2";
    do_alloc(50, 10);
    do_write(50, 32'hAAAA, 2, 2); do_read(50, 50);
    do_write(50, 32'hBBBB, 3, 1); do_read(50, 50);
    do_write(50, 32'hCCCC, 1, 3); do_read(50, 50);

    // R4: same-cycle read of the written register misses
    cur_req = "R4";
    wr_en = 1; wr_preg = 7'd50; wr_data = 32'h1234; wr_pred = 4; wr_byp = 0;
    rd_en = '1; rd_preg = {7'd50, 7'd50};
    step();
    do_read(50, 50);

    // R5: invalid way 0 before way 1
    cur_req = "R5";
    do_alloc(60, 12); do_alloc(61, 12);
    do_write(60, 32'h60, 1, 0); do_write(61, 32'h61, 5, 0); do_read(60, 61);

    // R6: fewest remaining uses replaced (60 has 0 left after the read)
    cur_req = "R6";
    do_alloc(62, 12);
    do_write(62, 32'h62, 2, 0); do_read(60, 61); do_read(62, 62);

    // R8: two ports hitting one entry subtract two
    cur_req = "R8";
    do_alloc(70, 14); do_alloc(71, 14); do_alloc(72, 14);
    do_write(70, 32'h70, 2, 0); do_write(71, 32'h71, 3, 0);
    do_read(70, 70);
    do_write(72, 32'h72, 1, 0); do_read(70, 71); do_read(72, 72);

    // R7: equal counts, flag selects
    cur_req = "R7";
    do_alloc(80, 16); do_alloc(81, 16); do_alloc(82, 16); do_alloc(83, 16);
    do_write(80, 32'h80, 5, 0); do_write(81, 32'h81, 5, 0);
    do_read(81, 80);
    do_write(82, 32'h82, 4, 0); do_read(80, 81); do_read(82, 82);
    do_write(83, 32'h83, 4, 0); do_read(80, 81); do_read(82, 83);

    // R11: rewrite in place
    cur_req = "R11";
    do_write(82, 32'hF00D, 9, 0); do_read(82, 83);

    // R10: invalidate, and write of the same register dropped
    cur_req = "R10";
    inv_en = 1; inv_preg = 7'd83; step();
    do_read(83, 82);
    inv_en = 1; inv_preg = 7'd82; wr_en = 1; wr_preg = 7'd82; wr_data = 32'h5; wr_pred = 3;
    step();
    do_read(82, 83);

    // R1: flush wins over a write in the same cycle
    cur_req = "R1";
    do_write(9, 32'h99, 4, 0);
    flush = 1; wr_en = 1; wr_preg = 7'd17; wr_data = 32'h1717; wr_pred = 3; step();
    do_read(9, 17); do_read(8, 40);

    // R3: random traffic against the reference
    cur_req = "R3";
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(999));
      if (r < 40) begin
        alloc_en = 1; alloc_preg = PREG_W'($urandom_range(NUM_PREG-1));
        alloc_idx = SET_W'($urandom_range(7));
        inv_en = 1; inv_preg = alloc_preg;
      end else if (r < 70) begin
        inv_en = 1; inv_preg = PREG_W'(recent[$urandom_range(7)]);
      end
      if (r < 4) flush = 1;
      if ($urandom_range(99) < 60) begin
        wr_en = 1; wr_preg = PREG_W'($urandom_range(NUM_PREG-1));
        wr_data = $urandom(); wr_pred = 4'($urandom_range(15)); wr_byp = 4'($urandom_range(3));
        recent[n % 8] = int'(wr_preg);
      end
      for (int p = 0; p < NUM_RD; p++) begin
        rd_en[p] = ($urandom_range(99) < 75);
        rd_preg[p*PREG_W +: PREG_W] = PREG_W'(recent[$urandom_range(7)]);
      end
      step();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule